// File: doc/BRIEF.md
# Clock-Control Status Register File

This block is the software-visible register window of a multi-domain clock generator. It sits behind an AXI4-Lite slave port whose address has already been narrowed to a 12-bit offset inside a 4KB window. It returns fixed identification words and a mask of the generated clocks that are present. It also reports the lock state of four PLLs, each passed through a synchronizer first.

Three writable controls drive a downstream reset distribution block. The first is a 32-bit global reset word. The second is a ten-bit vector of per-domain reset requests. The third is a flag that stops the incoming main reset from reaching any domain. While the global reset word is nonzero, the request vector presented downstream is forced to all ones. The per-domain register therefore only takes effect once the global reset is released. Offsets outside the map read as a fixed sentinel, and writes to them are dropped.

Top module: `clkctl_regfile`

## Requirements
- R1: Word offset 0x00 reads 0x9048_1D0F, offset 0x04 reads 0x0201_0000, and offset 0x08 reads the build stamp 0x0923_2223 (month, day, year, hour from the top byte down). Writes to these offsets change nothing.
- R2: Offset 0x0C reads 0x0000_01FF: bits 8:0 are one (nine clocks present) and bits 31:9 are zero. Writes to it change nothing.
- R3: After reset, the global word is 0, the request field is 0x3FE and the disable bit is 0. The outputs then show glb_rst_o=0, dom_rst_req_o=0x3FE and main_rst_dis_o=0.
- R4: Offset 0x10 is a 32-bit read-write global reset word. glb_rst_o is 1 exactly while that word is nonzero.
- R5: Offset 0x14 holds the request field in bits 9:0, and bits 31:10 read zero. dom_rst_req_o equals that field while the global word is zero, and it is all ones while the global word is nonzero.
- R6: Offset 0x18 bit 0 is read-write and drives main_rst_dis_o. Bits 31:1 read zero.
- R7: Offset 0x20 returns lock_i[0], lock_i[1], lock_i[2] and lock_i[3] at bits 0, 4, 6 and 8, after a two-flop synchronizer. All its other bits read zero.
- R8: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 or 0x20 returns 0xDEAD_DEC0. A write to any such offset changes no register and no output. Address bits 1:0 are ignored.
- R9: The write address and write data may be accepted in either order or in the same cycle. The register and the outputs update on the clock edge after both are held, and BVALID rises on that same edge with BRESP=0. BVALID stays high until BREADY.
- R10: Read data and RVALID appear on the edge that accepts the read address, with RRESP=0. RDATA stays stable while RVALID is high and RREADY is low.
- R11: Writes update only the byte lanes whose WSTRB bit is set. WSTRB bit n covers data bits 8n+7:8n.
- R12: Only one transaction is in flight at a time. No address is accepted while a response is pending or a write is half-received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 4 | Raw PLL lock flags: group A, B, C, memory-interface PLL |
| s_awaddr | input | 12 | Write offset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 12 | Read offset |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| glb_rst_o | output | 1 | Global reset to PLLs and reset distribution |
| dom_rst_req_o | output | 10 | Per-domain reset requests, gated by the global word |
| main_rst_dis_o | output | 1 | Stop incoming main reset reaching the domains |

## Verification
A write takes one edge for the last of its address and data beats to be held. The register, the control outputs and BVALID all change on the following edge. The bench therefore checks at the falling edge between those two edges that BVALID is still low, and at the next falling edge that BVALID and the new outputs are present. A read returns its data at the falling edge right after the accepting edge, and the bench checks it there and once more a cycle later with RREADY held low. A lock change reaches the status word only after two edges, so the bench reads once straight after the change, expects the old value, and then reads again.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int WIN_ADDR_W = 12;
    localparam int REG_DATA_W = 32;
    localparam int DOM_COUNT  = 10;
    localparam int CLK_COUNT  = 9;
    localparam int PLL_COUNT  = 4;

    // word indices (byte offset / 4) of the register map
    localparam int WI_ID    = 0;
    localparam int WI_VER   = 1;
    localparam int WI_BUILD = 2;
    localparam int WI_CLKS  = 3;
    localparam int WI_GLB   = 4;
    localparam int WI_DOM   = 5;
    localparam int WI_DIS   = 6;
    localparam int WI_LOCK  = 8;

    localparam logic [REG_DATA_W-1:0] UNMAPPED_WORD = 32'hDEAD_DEC0;

    // bit position of each PLL lock flag inside the lock status word
    localparam int LOCK_BIT [PLL_COUNT] = '{0, 4, 6, 8};

    typedef struct packed {
        logic [REG_DATA_W-1:0] glb;
        logic [DOM_COUNT-1:0]  dom;
        logic                  dis;
    } ctl_regs_t;

    function automatic logic [REG_DATA_W-1:0] lane_merge(
        input logic [REG_DATA_W-1:0]   old_v,
        input logic [REG_DATA_W-1:0]   new_v,
        input logic [REG_DATA_W/8-1:0] strb
    );
        logic [REG_DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < REG_DATA_W/8; b++) begin
            if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkctl_axil_port.sv
module clkctl_axil_port #(
    parameter int AW = 12,
    parameter int DW = 32,
    localparam int SW = DW / 8,
    localparam int WW = AW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] s_awaddr,
    input  logic          s_awvalid,
    output logic          s_awready,
    input  logic [DW-1:0] s_wdata,
    input  logic [SW-1:0] s_wstrb,
    input  logic          s_wvalid,
    output logic          s_wready,
    output logic [1:0]    s_bresp,
    output logic          s_bvalid,
    input  logic          s_bready,
    input  logic          s_arvalid,
    output logic          s_arready,
    input  logic [DW-1:0] rd_word_i,
    output logic [DW-1:0] s_rdata,
    output logic [1:0]    s_rresp,
    output logic          s_rvalid,
    input  logic          s_rready,
    output logic          wr_en_o,
    output logic [WW-1:0] wr_word_o,
    output logic [DW-1:0] wr_data_o,
    output logic [SW-1:0] wr_strb_o
);

    typedef struct packed {
        logic          aw_full;
        logic          w_full;
        logic [WW-1:0] word;
        logic [DW-1:0] data;
        logic [SW-1:0] strb;
        logic          bvalid;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } port_t;

    port_t st_d, st_q;
    logic  unused_aw_low;

    assign unused_aw_low = ^s_awaddr[1:0];

    assign s_awready = !st_q.aw_full && !st_q.bvalid && !st_q.rvalid;
    assign s_wready  = !st_q.w_full  && !st_q.bvalid && !st_q.rvalid;
    assign s_arready = !(st_q.aw_full || st_q.w_full || st_q.bvalid || st_q.rvalid
                         || s_awvalid || s_wvalid);
    assign wr_en_o   = st_q.aw_full && st_q.w_full;

    always_comb begin
        st_d = st_q;
        if (s_awvalid && s_awready) begin
            st_d.aw_full = 1'b1;
            st_d.word    = s_awaddr[AW-1:2];
        end
        if (s_wvalid && s_wready) begin
            st_d.w_full = 1'b1;
            st_d.data   = s_wdata;
            st_d.strb   = s_wstrb;
        end
        if (wr_en_o) begin
            st_d.aw_full = 1'b0;
            st_d.w_full  = 1'b0;
            st_d.bvalid  = 1'b1;
        end
        if (st_q.bvalid && s_bready) st_d.bvalid = 1'b0;
        if (s_arvalid && s_arready) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_word_i;
        end
        if (st_q.rvalid && s_rready) st_d.rvalid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_word_o = st_q.word;
    assign wr_data_o = st_q.data;
    assign wr_strb_o = st_q.strb;
    assign s_bvalid  = st_q.bvalid;
    assign s_rvalid  = st_q.rvalid;
    assign s_rdata   = st_q.rdata;
    assign s_bresp   = 2'b00;
    assign s_rresp   = 2'b00;

    assert_commit_raises_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> s_bvalid);
    assert_b_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid);
    assert_rdata_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
    assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_bvalid, s_rvalid}));

endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
    import clkctl_pkg::*;
#(
    parameter int              ADDR_W     = WIN_ADDR_W,
    parameter int              DATA_W     = REG_DATA_W,
    parameter int              N_DOM      = DOM_COUNT,
    parameter int              N_CLK      = CLK_COUNT,
    parameter int              N_PLL      = PLL_COUNT,
    parameter int              SYNC_DEPTH = 2,
    parameter logic [31:0]     ID_WORD    = 32'h9048_1D0F,
    parameter logic [31:0]     VER_WORD   = 32'h0201_0000,
    parameter logic [31:0]     BUILD_WORD = 32'h0923_2223,
    parameter logic [N_DOM-1:0] DOM_INIT  = 10'h3FE,
    localparam int STRB_W = DATA_W / 8,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PLL-1:0]  lock_i,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              glb_rst_o,
    output logic [N_DOM-1:0]  dom_rst_req_o,
    output logic              main_rst_dis_o
);

    ctl_regs_t          st_d, st_q;
    logic               wr_en;
    logic [WORD_W-1:0]  wr_word;
    logic [DATA_W-1:0]  wr_data;
    logic [STRB_W-1:0]  wr_strb;
    logic [DATA_W-1:0]  rd_word;
    logic [DATA_W-1:0]  lock_word;
    logic [N_PLL-1:0]   lock_s;
    logic               unused_ar_low;

    assign unused_ar_low = ^s_araddr[1:0];

    clkctl_axil_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .rd_word_i (rd_word),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .wr_en_o   (wr_en),
        .wr_word_o (wr_word),
        .wr_data_o (wr_data),
        .wr_strb_o (wr_strb)
    );

    clkctl_sync #(.WIDTH(N_PLL), .STAGES(SYNC_DEPTH)) u_lock_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lock_i),
        .sync_o  (lock_s)
    );

    // spread synchronized lock flags onto their status bit positions
    always_comb begin
        lock_word = '0;
        for (int i = 0; i < N_PLL; i++) begin
            lock_word[LOCK_BIT[i]] = lock_s[i];
        end
    end

    // read mux, evaluated on the offered read address
    always_comb begin
        case (int'(s_araddr[ADDR_W-1:2]))
            WI_ID:    rd_word = ID_WORD;
            WI_VER:   rd_word = VER_WORD;
            WI_BUILD: rd_word = BUILD_WORD;
            WI_CLKS:  rd_word = DATA_W'({N_CLK{1'b1}});
            WI_GLB:   rd_word = st_q.glb;
            WI_DOM:   rd_word = DATA_W'(st_q.dom);
            WI_DIS:   rd_word = DATA_W'(st_q.dis);
            WI_LOCK:  rd_word = lock_word;
            default:  rd_word = UNMAPPED_WORD;
        endcase
    end

    // next-state of the writable controls
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (int'(wr_word))
                WI_GLB: st_d.glb = lane_merge(st_q.glb, wr_data, wr_strb);
                WI_DOM: st_d.dom = N_DOM'(lane_merge(DATA_W'(st_q.dom), wr_data, wr_strb));
                WI_DIS: st_d.dis = wr_strb[0] ? wr_data[0] : st_q.dis;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.glb <= '0;
            st_q.dom <= DOM_INIT;
            st_q.dis <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign glb_rst_o      = |st_q.glb;
    assign dom_rst_req_o  = glb_rst_o ? {N_DOM{1'b1}} : st_q.dom;
    assign main_rst_dis_o = st_q.dis;

    assert_glb_forces_domains_R5: assert property (@(posedge clk) disable iff (!rst_n)
        glb_rst_o |-> (&dom_rst_req_o));
    assert_controls_only_move_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(glb_rst_o) && $stable(dom_rst_req_o) && $stable(main_rst_dis_o));
    assert_lock_bits_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && $rose(s_rvalid) && (int'($past(s_araddr[ADDR_W-1:2])) == WI_LOCK)
        |-> ($countones(s_rdata) <= N_PLL));

endmodule

// File: tb/clkctl_regfile_test.sv
module clkctl_regfile_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lock_i = '0;
    logic [11:0] s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b0;
    logic [11:0] s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b0;
    logic        glb_rst_o;
    logic [9:0]  dom_rst_req_o;
    logic        main_rst_dis_o;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model
    logic [31:0] m_glb = '0;
    logic [9:0]  m_dom = 10'h3FE;
    logic        m_dis = 1'b0;
    logic [3:0]  m_lock = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl_regfile uut (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .glb_rst_o(glb_rst_o), .dom_rst_req_o(dom_rst_req_o), .main_rst_dis_o(main_rst_dis_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [3:0] strb);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{strb[b]}};
        return m;
    endfunction

    function automatic logic [31:0] exp_read(input int word);
        logic [31:0] lw;
        lw = '0;
        lw[0] = m_lock[0]; lw[4] = m_lock[1]; lw[6] = m_lock[2]; lw[8] = m_lock[3];
        case (word)
            0: return 32'h9048_1D0F;
            1: return 32'h0201_0000;
            2: return 32'h0923_2223;
            3: return 32'h0000_01FF;
            4: return m_glb;
            5: return {22'd0, m_dom};
            6: return {31'd0, m_dis};
            8: return lw;
            default: return 32'hDEAD_DEC0;
        endcase
    endfunction

    function automatic void model_write(input int word, input logic [31:0] d, input logic [3:0] strb);
        logic [31:0] m, t;
        m = mask_of(strb);
        case (word)
            4: m_glb = (m_glb & ~m) | (d & m);
            5: begin t = ({22'd0, m_dom} & ~m) | (d & m); m_dom = t[9:0]; end
            6: if (strb[0]) m_dis = d[0];
            default: ;
        endcase
    endfunction

    task automatic check_outputs(input string req);
        check({req, " glb_rst_o"}, {31'd0, glb_rst_o}, {31'd0, (m_glb != 0)});
        check({req, " dom_rst_req_o"}, {22'd0, dom_rst_req_o},
              {22'd0, (m_glb != 0) ? 10'h3FF : m_dom});
        check({req, " main_rst_dis_o"}, {31'd0, main_rst_dis_o}, {31'd0, m_dis});
    endtask

    // order: 0 same cycle, 1 address first, 2 data first
    task automatic do_write(input logic [11:0] addr, input logic [31:0] d,
                            input logic [3:0] strb, input int order);
        bit aw_done, w_done, aw_hs, w_hs;
        aw_done = 0; w_done = 0;
        @(negedge clk);
        s_awaddr = addr; s_wdata = d; s_wstrb = strb; s_bready = 1'b1;
        s_awvalid = (order != 2);
        s_wvalid  = (order != 1);
        while (!(aw_done && w_done)) begin
            #1;
            aw_hs = s_awvalid && s_awready;
            w_hs  = s_wvalid && s_wready;
            @(posedge clk);
            @(negedge clk);
            if (aw_hs) begin s_awvalid = 1'b0; aw_done = 1; end
            if (w_hs)  begin s_wvalid  = 1'b0; w_done  = 1; end
            if (order == 1 && aw_done && !w_done) s_wvalid = 1'b1;
            if (order == 2 && w_done && !aw_done) s_awvalid = 1'b1;
        end
        // R9: both held now, commit and response on the next edge
        check("R9 bvalid low before commit", {31'd0, s_bvalid}, 32'd0);
        @(negedge clk);
        check("R9 bvalid after commit", {31'd0, s_bvalid}, 32'd1);
        check("R9 bresp okay", {30'd0, s_bresp}, 32'd0);
        model_write(int'(addr[11:2]), d, strb);
        @(negedge clk);
        s_bready = 1'b0;
        check("R9 bvalid cleared", {31'd0, s_bvalid}, 32'd0);
    endtask

    task automatic do_read(input logic [11:0] addr, input string req, output logic [31:0] got);
        @(negedge clk);
        s_araddr = addr; s_arvalid = 1'b1;
        #1;
        check("R12 arready when idle", {31'd0, s_arready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        got = s_rdata;
        check("R10 rvalid after accept", {31'd0, s_rvalid}, 32'd1);
        check({req, " rdata"}, s_rdata, exp_read(int'(addr[11:2])));
        check("R10 rresp okay", {30'd0, s_rresp}, 32'd0);
        #1;
        check("R12 no accept while read pending", {31'd0, s_awready | s_arready}, 32'd0);
        @(negedge clk);
        check("R10 rdata held", s_rdata, got);
        s_rready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_rready = 1'b0;
        check("R10 rvalid cleared", {31'd0, s_rvalid}, 32'd0);
    endtask

    task automatic read_check(input logic [11:0] addr, input string req);
        logic [31:0] g;
        do_read(addr, req, g);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        check_outputs("R3 reset");
        check("R3 bvalid idle", {31'd0, s_bvalid}, 32'd0);
        check("R3 rvalid idle", {31'd0, s_rvalid}, 32'd0);

        // R1 R2 R3 R7 R8: sweep every word offset of the window
        for (int w = 0; w < 1024; w++) begin
            read_check(12'(w * 4), "R8 sweep read");
        end
        // R8: ignored low address bits
        read_check(12'h003, "R1 low bits ignored");
        read_check(12'h011, "R8 low bits ignored");

        // R8 R1 R2: writes to read-only and unmapped offsets are dropped
        for (int w = 0; w < 1024; w++) begin
            if (w == 4 || w == 5 || w == 6) continue;
            if (w > 12 && (w % 37) != 0 && w != 1023) continue;
            do_write(12'(w * 4), 32'hFFFF_FFFF, 4'hF, w % 3);
            check_outputs("R8 unmapped write");
        end
        for (int w = 0; w < 9; w++) read_check(12'(w * 4), "R8 after junk writes");

        // R5: request field while global word is zero
        do_write(12'h014, 32'hFFFF_FC00, 4'hF, 0);
        check_outputs("R5 clear requests");
        read_check(12'h014, "R5 upper bits zero");
        do_write(12'h014, 32'h0000_0155, 4'hF, 1);
        check_outputs("R5 pattern");

        // R11 R4: every strobe combination on the global word
        for (int s = 0; s < 16; s++) begin
            do_write(12'h010, 32'hA5C3_0F81 ^ {4{8'(s)}}, 4'(s), s % 3);
            check_outputs("R4 R11 strobe sweep");
            read_check(12'h010, "R11 strobe readback");
        end
        // R4 R5: releasing the global word exposes the request field again
        do_write(12'h010, 32'h0000_0000, 4'hF, 2);
        check_outputs("R4 release");
        do_write(12'h010, 32'h0100_0000, 4'h8, 0);
        check_outputs("R4 single top byte");
        do_write(12'h010, 32'h0000_0000, 4'hF, 1);
        check_outputs("R5 gate reopened");

        // R11: strobes on the request field
        do_write(12'h014, 32'h0000_03FF, 4'h2, 0);
        check_outputs("R11 dom lane1");
        read_check(12'h014, "R11 dom readback");

        // R6
        do_write(12'h018, 32'hFFFF_FFFF, 4'hF, 2);
        check_outputs("R6 set");
        read_check(12'h018, "R6 readback");
        do_write(12'h018, 32'h0000_0000, 4'hE, 1);
        check_outputs("R6 masked lane0");
        do_write(12'h018, 32'h0000_0000, 4'h1, 0);
        check_outputs("R6 clear");

        // R7: each lock input, two-stage delay
        for (int p = 0; p < 16; p++) begin
            logic [31:0] g;
            @(negedge clk);
            lock_i = 4'(p);
            do_read(12'h020, "R7 before sync", g); // captured at first edge: old value
            m_lock = 4'(p);
            read_check(12'h020, "R7 lock map");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule